// File: doc/BRIEF.md
# Iteration-Based Write Power Token Manager

This block decides when multi-level-cell writes may start, against a shared pool of power tokens. One token stands for the power of one cell RESET. A write request names how many cells it will change. Requests wait in a first-in, first-out queue. The head request is granted only when the pool holds at least that many tokens and a tracking slot is free. On a grant, the block takes that many tokens from the pool, records the amount against a slot, and reports the slot number to the write engine.

The block does not hold a write's tokens until the write completes. The write engine reports the end of each iteration, giving the slot, whether the pass was RESET or SET, and how many cells are still being programmed.

- At the end of the RESET pass, the allocation falls to ceil(alloc/C). RESET power is C times SET power, and C is a power of two.
- At the end of each SET pass, the allocation falls to ceil(cells_left/C), but it never grows.
- A report with zero cells left releases the whole allocation and frees the slot.

The surplus from any report returns to the pool in the same cycle. A grant decided in that cycle already sees it.

Top module: `write_power_budget`

## Requirements
- R1: After reset, `avail_tokens` equals `POOL_TOKENS`, `grant_valid` and `stall` are low, and `req_ready` is high.
- R2: The head request is granted when its cell count is at most the pool value, including equality. `grant_valid` pulses for one cycle with the slot and cell count, and `avail_tokens` drops by the cell count. The grant shows on the second rising edge after the request is presented.
- R3: While the head request needs more tokens than the pool holds, `stall` is high, no grant is issued, and `avail_tokens` is unchanged.
- R4: A report with `iter_reset`=1 and a nonzero cell count shrinks the slot's allocation from A to ceil(A/C). The difference returns to the pool. With the default C=2, half the tokens are returned, rounded down.
- R5: A report with `iter_reset`=0 and L>0 cells left sets the allocation to min(A, ceil(L/C)). The surplus returns to the pool.
- R6: A report with zero cells left returns all of the slot's tokens and frees the slot.
- R7: Requests are granted strictly in arrival order. A small request never passes a stalled head.
- R8: Tokens released by a report in a cycle count toward that same cycle's grant decision.
- R9: A report naming a slot that is not in use, or a slot number of `SLOTS` or above, leaves `avail_tokens` unchanged.
- R10: A request with zero cells is discarded. It produces no grant, no stall and no change to the pool.
- R11: While every slot is in use, the head request stalls even if tokens suffice. A slot freed by a report becomes usable on the next cycle.
- R12: `avail_tokens` never exceeds `POOL_TOKENS`, and it always equals `POOL_TOKENS` minus the sum of the live allocations.
- R13: `req_ready` is low while the queue holds `QUEUE_DEPTH` entries, and a request presented then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present this cycle |
| req_cells | input | CELL_W | Number of cells the write changes |
| req_ready | output | 1 | Queue can take a request |
| iter_valid | input | 1 | Iteration-end report present |
| iter_slot | input | SLOT_W | Slot the report refers to |
| iter_reset | input | 1 | 1 = RESET pass ended, 0 = SET pass ended |
| iter_left | input | CELL_W | Cells still being programmed |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_slot | output | SLOT_W | Slot assigned to the granted write |
| grant_cells | output | CELL_W | Cell count of the granted write |
| avail_tokens | output | TOK_W | Tokens currently free in the pool |
| stall | output | 1 | Head request is waiting for tokens or a slot |

## Verification
A request is captured by the queue on one edge and decided on the next, so the bench samples the grant, the stall flag and the pool on the falling edge after that second rising edge. An iteration report changes the pool on the very edge that samples it, so the bench reads the pool on the falling edge that follows. Any grant unlocked by the release appears in that same sample, which is how the same-cycle release rule is observed. A slot freed by a report is reusable one edge later, and the bench samples the resulting grant one cycle after the release.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    // Rounded-up division by a power of two: ceil(v / 2**sh)
    function automatic int unsigned ceil_shift(input int unsigned v, input int unsigned sh);
        int unsigned mask;
        mask = (32'd1 << sh) - 32'd1;
        return (v + mask) >> sh;
    endfunction

endpackage

// File: rtl/wpb_req_fifo.sv
module wpb_req_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok, pop_ok;

    assign full       = (st_q.cnt == CNT_W'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rp];
    assign push_ok    = push && !full;
    assign pop_ok     = pop && head_valid;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_ok) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the grant logic only takes the head when one exists
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    // R13: a full queue keeps its occupancy unless an entry leaves
    assert_full_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

endmodule

// File: rtl/wpb_reclaim.sv
module wpb_reclaim #(
    parameter int TOK_W     = 10,
    parameter int CELL_W    = 10,
    parameter int SET_SHIFT = 1
) (
    input  logic              is_reset,
    input  logic [CELL_W-1:0] cells_left,
    input  logic [TOK_W-1:0]  cur_amt,
    output logic [TOK_W-1:0]  new_amt,
    output logic [TOK_W-1:0]  give_back,
    output logic              frees
);
    import wpb_pkg::*;

    int unsigned cur_i, want_i, next_i;

    always_comb begin
        cur_i  = 32'(cur_amt);
        want_i = ceil_shift(32'(cells_left), SET_SHIFT);
        frees  = (cells_left == '0);
        if (frees) begin
            next_i = 0;
        end else if (is_reset) begin
            // RESET pass done: keep one C-th, return the rest
            next_i = ceil_shift(cur_i, SET_SHIFT);
        end else begin
            // SET pass done: follow the remaining cells, never grow
            next_i = (want_i < cur_i) ? want_i : cur_i;
        end
        new_amt   = TOK_W'(next_i);
        give_back = TOK_W'(cur_i - next_i);
    end

endmodule

// File: rtl/wpb_slot_table.sv
module wpb_slot_table #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2,
    parameter int TOK_W  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [SLOT_W-1:0]           alloc_slot,
    input  logic [TOK_W-1:0]            alloc_amt,
    input  logic                        upd_en,
    input  logic [SLOT_W-1:0]           upd_slot,
    input  logic [TOK_W-1:0]            upd_amt,
    input  logic                        upd_free,
    output logic [SLOTS-1:0]            live,
    output logic [SLOTS-1:0][TOK_W-1:0] amt,
    output logic                        any_free,
    output logic [SLOT_W-1:0]           free_idx
);
    typedef struct packed {
        logic [SLOTS-1:0]            live;
        logic [SLOTS-1:0][TOK_W-1:0] amt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    assign live = tbl_q.live;
    assign amt  = tbl_q.amt;

    // lowest-numbered free slot
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!tbl_q.live[i]) begin
                any_free = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            tbl_d.amt[upd_slot] = upd_amt;
            if (upd_free) tbl_d.live[upd_slot] = 1'b0;
        end
        if (alloc_en) begin
            tbl_d.live[alloc_slot] = 1'b1;
            tbl_d.amt[alloc_slot]  = alloc_amt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // R11: a grant only lands on a slot that was free
    assert_alloc_free_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !tbl_q.live[alloc_slot]);

    // R4 / R5: while a write stays live its allocation only shrinks
    for (genvar g = 0; g < SLOTS; g++) begin : g_shrink
        assert_alloc_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl_q.live[g] && $past(tbl_q.live[g])) |-> (tbl_q.amt[g] <= $past(tbl_q.amt[g])));
    end

endmodule

// File: rtl/write_power_budget.sv
module write_power_budget #(
    parameter int POOL_TOKENS = 560,
    parameter int CELL_W      = 10,
    parameter int SET_SHIFT   = 1,
    parameter int SLOTS       = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int TOK_W       = $clog2(POOL_TOKENS + 1),
    parameter int SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CELL_W-1:0] req_cells,
    output logic              req_ready,
    input  logic              iter_valid,
    input  logic [SLOT_W-1:0] iter_slot,
    input  logic              iter_reset,
    input  logic [CELL_W-1:0] iter_left,
    output logic              grant_valid,
    output logic [SLOT_W-1:0] grant_slot,
    output logic [CELL_W-1:0] grant_cells,
    output logic [TOK_W-1:0]  avail_tokens,
    output logic              stall
);
    typedef struct packed {
        logic [TOK_W-1:0]  avail;
        logic              gv;
        logic [SLOT_W-1:0] gslot;
        logic [CELL_W-1:0] gcells;
        logic              stall;
    } top_st_t;

    top_st_t st_d, st_q;

    // queue
    logic              q_full, q_push, q_pop, q_valid;
    logic [CELL_W-1:0] q_head;

    // slot table
    logic [SLOTS-1:0]            slot_live;
    logic [SLOTS-1:0][TOK_W-1:0] slot_amt;
    logic                        slot_any_free;
    logic [SLOT_W-1:0]           slot_free_idx;

    // reclaim
    logic                 rep_hit, rep_slot_ok, rep_frees;
    logic [TOK_W-1:0]     rep_cur, rep_new, rep_back;

    logic                 can_grant;
    int unsigned          pool_after, head_need;

    assign q_push    = req_valid && (req_cells != '0);
    assign req_ready = !q_full;

    wpb_req_fifo #(
        .DEPTH (QUEUE_DEPTH),
        .DATA_W(CELL_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (req_cells),
        .full      (q_full),
        .pop       (q_pop),
        .head_valid(q_valid),
        .head_data (q_head)
    );

    assign rep_slot_ok = (32'(iter_slot) < SLOTS);
    assign rep_hit     = iter_valid && rep_slot_ok && slot_live[iter_slot];
    assign rep_cur     = rep_slot_ok ? slot_amt[iter_slot] : '0;

    wpb_reclaim #(
        .TOK_W    (TOK_W),
        .CELL_W   (CELL_W),
        .SET_SHIFT(SET_SHIFT)
    ) u_reclaim (
        .is_reset  (iter_reset),
        .cells_left(iter_left),
        .cur_amt   (rep_cur),
        .new_amt   (rep_new),
        .give_back (rep_back),
        .frees     (rep_frees)
    );

    always_comb begin
        pool_after = 32'(st_q.avail) + (rep_hit ? 32'(rep_back) : 32'd0);
        head_need  = 32'(q_head);
        can_grant  = q_valid && slot_any_free && (head_need <= pool_after);
    end

    assign q_pop = can_grant;

    wpb_slot_table #(
        .SLOTS (SLOTS),
        .SLOT_W(SLOT_W),
        .TOK_W (TOK_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (can_grant),
        .alloc_slot(slot_free_idx),
        .alloc_amt (TOK_W'(head_need)),
        .upd_en    (rep_hit),
        .upd_slot  (iter_slot),
        .upd_amt   (rep_new),
        .upd_free  (rep_frees),
        .live      (slot_live),
        .amt       (slot_amt),
        .any_free  (slot_any_free),
        .free_idx  (slot_free_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.gv     = can_grant;
        st_d.gslot  = can_grant ? slot_free_idx : st_q.gslot;
        st_d.gcells = can_grant ? q_head : st_q.gcells;
        st_d.stall  = q_valid && !can_grant;
        st_d.avail  = TOK_W'(pool_after - (can_grant ? head_need : 32'd0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.avail <= TOK_W'(POOL_TOKENS);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid  = st_q.gv;
    assign grant_slot   = st_q.gslot;
    assign grant_cells  = st_q.gcells;
    assign avail_tokens = st_q.avail;
    assign stall        = st_q.stall;

    // sum of allocations held by live slots, used by the checks below
    int unsigned held_sum;
    always_comb begin
        held_sum = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_live[i]) held_sum = held_sum + 32'(slot_amt[i]);
        end
    end

    assert_pool_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.avail) <= POOL_TOKENS);

    assert_tokens_conserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.avail) + held_sum) == POOL_TOKENS);

    assert_grant_from_queue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gv |-> $past(q_valid));

    assert_stall_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stall |-> (!st_q.gv && $past(q_valid)));

endmodule

// File: tb/sim_write_power_budget.sv
module sim_write_power_budget;
    localparam int POOL   = 560;
    localparam int CELL_W = 10;
    localparam int SLOTS  = 4;
    localparam int TOK_W  = $clog2(POOL + 1);
    localparam int SLOT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [CELL_W-1:0] req_cells = '0;
    logic              req_ready;
    logic              iter_valid = 1'b0;
    logic [SLOT_W-1:0] iter_slot = '0;
    logic              iter_reset = 1'b0;
    logic [CELL_W-1:0] iter_left = '0;
    logic              grant_valid;
    logic [SLOT_W-1:0] grant_slot;
    logic [CELL_W-1:0] grant_cells;
    logic [TOK_W-1:0]  avail_tokens;
    logic              stall;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;
    bit over_pool = 0;

    always #2.5 clk = ~clk;

    write_power_budget u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cells(req_cells), .req_ready(req_ready),
        .iter_valid(iter_valid), .iter_slot(iter_slot), .iter_reset(iter_reset),
        .iter_left(iter_left),
        .grant_valid(grant_valid), .grant_slot(grant_slot), .grant_cells(grant_cells),
        .avail_tokens(avail_tokens), .stall(stall)
    );

    always @(negedge clk) begin
        if (rst_n && int'(avail_tokens) > POOL) over_pool = 1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d exp %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // present one request for one edge
    task automatic push_req(input int cells);
        req_valid = 1'b1;
        req_cells = CELL_W'(cells);
        tick();
        req_valid = 1'b0;
    endtask

    // present a request, then wait for the deciding edge
    task automatic submit(input int cells, output int slot);
        push_req(cells);
        tick();
        slot = int'(grant_slot);
    endtask

    task automatic report(input int slot, input bit is_rst, input int left);
        iter_valid = 1'b1;
        iter_slot  = SLOT_W'(slot);
        iter_reset = is_rst;
        iter_left  = CELL_W'(left);
        tick();
        iter_valid = 1'b0;
    endtask

    task automatic release_all();
        for (int s = 0; s < SLOTS; s++) report(s, 1'b0, 0);
    endtask

    typedef struct packed {
        int cells;
        int set_left;
        int e_grant;
        int e_reset;
        int e_set;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{100,  40, 460, 510, 540},
        '{560, 300,   0, 280, 410},
        '{  7,   3, 553, 556, 558},
        '{  1,   1, 559, 559, 559},
        '{ 50, 200, 510, 535, 535},
        '{ 33,   9, 527, 543, 555}
    };

    initial begin
        int sa, sb, sc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "avail", int'(avail_tokens), POOL);
        chk("R1", "grant_valid", int'(grant_valid), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        rst_n = 1'b1;
        tick();

        // vector table: one full write lifetime per entry
        foreach (VECS[i]) begin
            submit(VECS[i].cells, sa);
            chk("R2", "grant_valid", int'(grant_valid), 1);
            chk("R2", "grant_cells", int'(grant_cells), VECS[i].cells);
            chk("R2", "avail after grant", int'(avail_tokens), VECS[i].e_grant);
            report(sa, 1'b1, VECS[i].cells);
            chk("R4", "avail after RESET", int'(avail_tokens), VECS[i].e_reset);
            report(sa, 1'b0, VECS[i].set_left);
            chk("R5", "avail after SET", int'(avail_tokens), VECS[i].e_set);
            report(sa, 1'b0, 0);
            chk("R6", "avail after finish", int'(avail_tokens), POOL);
        end

        // R3 / R7 / R8: stalled head, ordering, same-cycle release
        submit(500, sa);
        chk("R2", "avail big grant", int'(avail_tokens), 60);
        push_req(100);
        push_req(10);
        tick();
        chk("R3", "stall", int'(stall), 1);
        chk("R3", "avail unchanged", int'(avail_tokens), 60);
        chk("R7", "small request not bypassing", int'(grant_valid), 0);
        report(sa, 1'b0, 0);
        chk("R8", "grant in release cycle", int'(grant_valid), 1);
        chk("R8", "granted cells", int'(grant_cells), 100);
        chk("R8", "avail", int'(avail_tokens), 460);
        tick();
        chk("R7", "second in order", int'(grant_cells), 10);
        chk("R7", "avail", int'(avail_tokens), 450);
        release_all();
        chk("R6", "avail after cleanup", int'(avail_tokens), POOL);

        // R9: reports on unused slots
        report(2, 1'b1, 5);
        report(3, 1'b0, 0);
        chk("R9", "avail unchanged", int'(avail_tokens), POOL);

        // R10: zero-cell request
        push_req(0);
        tick();
        chk("R10", "no grant", int'(grant_valid), 0);
        chk("R10", "no stall", int'(stall), 0);
        chk("R10", "avail", int'(avail_tokens), POOL);

        // R11: all slots busy
        for (int k = 0; k < SLOTS; k++) submit(10, sb);
        chk("R11", "avail four writes", int'(avail_tokens), 520);
        submit(10, sb);
        chk("R11", "no grant when full", int'(grant_valid), 0);
        chk("R11", "stall when full", int'(stall), 1);
        chk("R11", "avail", int'(avail_tokens), 520);
        report(0, 1'b0, 0);
        chk("R11", "no grant in free cycle", int'(grant_valid), 0);
        chk("R11", "avail after free", int'(avail_tokens), 530);
        tick();
        chk("R11", "grant next cycle", int'(grant_valid), 1);
        chk("R11", "avail after late grant", int'(avail_tokens), 520);
        release_all();
        chk("R12", "all returned", int'(avail_tokens), POOL);

        // R13: queue full drops extra request
        submit(560, sc);
        chk("R2", "grant at exact pool", int'(avail_tokens), 0);
        for (int k = 0; k < 4; k++) push_req(5);
        chk("R13", "req_ready low", int'(req_ready), 0);
        push_req(5);
        report(sc, 1'b0, 0);
        tick(); tick(); tick();
        chk("R13", "four grants", int'(avail_tokens), 540);
        tick(); tick();
        chk("R13", "dropped request absent", int'(avail_tokens), 540);
        chk("R13", "req_ready back", int'(req_ready), 1);
        release_all();
        chk("R12", "final pool", int'(avail_tokens), POOL);
        chk("R12", "never above pool", int'(over_pool), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule